// File: doc/BRIEF.md
# Two-to-One Image Store and Display Scaler

This block sits between a camera pixel stream, a frame memory and a display. On the store side it receives a 640 x 480 raster of one-byte pixels. It keeps one pixel from every 2 x 2 block, so each stored image is 320 x 240 pixels, or 76,800 bytes. That is a quarter of the full frame, and several images fit in a 512 KB memory. Each kept pixel goes out as a write with a linear byte address inside a selectable image slot.

On the display side the block receives the current screen coordinate from a display timing generator. It returns the memory address of the stored pixel that covers that coordinate. Each stored pixel therefore fills a 2 x 2 block on screen, and a reduced image still covers the whole 640 x 480 screen. Arbitration of the memory and generation of display timing belong to other blocks.

Top module: `frame_halver`

## Requirements
- R1: After a synchronous active-low reset, `wr_valid`, `store_err`, `view_err` are 0 and `rd_addr` is 0.
- R2: A pixel is written only when both its column and its row are even (bit 0 of each is 0). Pixels at odd columns or odd rows produce no write.
- R3: A kept pixel at (col, row) produces, one clock after it is accepted, `wr_valid`=1, `wr_data` equal to the pixel byte, and `wr_addr` = base + (row/2)*320 + col/2.
- R4: The slot base is slot*76,800. The slot is captured from `store_slot` on the start-of-frame pixel. Changes to `store_slot` later in the frame have no effect on addresses.
- R5: If the slot captured at start of frame is 6 or higher, no pixel of that frame is written and `store_err` is 1 from the next clock until a later start of frame with a slot of 0 to 5.
- R6: A pixel with `pix_valid`=1 and `pix_sof`=1 sits at (0,0). Each accepted pixel after it advances the column, and after column 639 the column returns to 0 and the row advances. A new start of frame restarts at (0,0) from any position.
- R7: Cycles with `pix_valid`=0 do not advance the position. Pixels that arrive after reset and before the first start of frame are discarded.
- R8: One clock after `view_x`, `view_y`, `view_slot` are presented with a slot of 0 to 5, `rd_addr` = slot*76,800 + (view_y>>1)*320 + (view_x>>1) and `view_err` is 0.
- R9: One clock after `view_slot` is 6 or higher, `view_err` is 1 and `rd_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Incoming pixel is present this cycle |
| pix_sof | input | 1 | Incoming pixel is the first of a frame |
| pix_data | input | 8 | Incoming pixel byte |
| store_slot | input | 3 | Image slot for the frame, sampled at start of frame |
| wr_valid | output | 1 | Write request for a kept pixel |
| wr_addr | output | 19 | Linear byte address of the write |
| wr_data | output | 8 | Byte to write |
| store_err | output | 1 | Current frame's slot is out of range; writes are suppressed |
| view_x | input | 10 | Screen column being displayed |
| view_y | input | 9 | Screen row being displayed |
| view_slot | input | 3 | Image slot to display |
| rd_addr | output | 19 | Read address into the stored image |
| view_err | output | 1 | Display slot is out of range |

## Verification
On every cycle, assertions check that the raster position stays inside the frame and that tracking, once started, never stops. They also check that no write leaves the slot region or happens while the store error is raised, and that an out-of-range display slot forces the read address to zero. Other behaviours need the bench's scenarios and its per-clock reference model: exact addresses, the even/even selection, slot capture only at start of frame, discarding of pixels before the first start of frame, idle gaps, row wrap after column 639, a frame restart in mid-row, and the 2 x 2 repetition on the display side.

// File: rtl/frame_halver_pkg.sv
// Package: shared constants and types for the two-to-one frame scaler.
// Assumes one byte per pixel and a linear byte-addressed frame memory.
package frame_halver_pkg;

    localparam int DEF_FULL_W = 640;
    localparam int DEF_FULL_H = 480;
    localparam int DEF_PIX_W  = 8;
    localparam int DEF_SLOTS  = 6;
    localparam int DEF_ADDR_W = 19;

    // Raster tracker state: waiting for the first start of frame, or running.
    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_RUN  = 1'b1
    } trk_state_e;

endpackage

// File: rtl/slot_base.sv
// Module: slot_base
// Maps an image slot index to the byte address where that slot starts.
// Slots are packed back to back, each SLOT_SZ bytes long. An index of
// SLOTS or more raises slot_bad and returns a base of zero.
// Assumes SLOTS*SLOT_SZ fits in ADDR_W bits.
module slot_base #(
    parameter int SLOTS   = 6,
    parameter int SLOT_W  = 3,
    parameter int ADDR_W  = 19,
    parameter int SLOT_SZ = 76800
) (
    input  logic [SLOT_W-1:0] slot,
    output logic [ADDR_W-1:0] base,
    output logic              slot_bad
);

    logic [ADDR_W-1:0] base_tbl [SLOTS];

    // One constant base per slot, built by the generate loop.
    for (genvar g = 0; g < SLOTS; g++) begin : g_tbl
        assign base_tbl[g] = ADDR_W'(g * SLOT_SZ);
    end

    // Select the base for the slot; out-of-range slots give zero.
    always_comb begin
        base = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (slot == SLOT_W'(i)) begin
                base = base_tbl[i];
            end
        end
    end

    // Range test done one bit wider so that SLOTS == 2**SLOT_W also works.
    assign slot_bad = ({1'b0, slot} >= (SLOT_W + 1)'(SLOTS));

endmodule

// File: rtl/raster_tracker.sv
// Module: raster_tracker
// Follows the position of each accepted pixel in a FULL_W x FULL_H raster.
// A valid pixel flagged as start of frame sits at (0,0). Pixels before the
// first start of frame are not live. The column wraps after FULL_W-1 and
// advances the row; the row wraps after FULL_H-1.
// Outputs are combinational and describe the pixel on the inputs this cycle.
module raster_tracker
    import frame_halver_pkg::*;
#(
    parameter int FULL_W = 640,
    parameter int FULL_H = 480,
    parameter int COL_W  = 10,
    parameter int ROW_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic             cur_live,
    output logic             frame_start,
    output logic [COL_W-1:0] cur_col,
    output logic [ROW_W-1:0] cur_row
);

    trk_state_e       st_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic             col_last;
    logic             row_last;

    // Position of the pixel on the inputs: a start of frame forces (0,0).
    always_comb begin
        frame_start = in_valid && in_sof;
        cur_live    = frame_start || (in_valid && (st_q == TRK_RUN));
        cur_col     = in_sof ? '0 : col_q;
        cur_row     = in_sof ? '0 : row_q;
        col_last    = (cur_col == COL_W'(FULL_W - 1));
        row_last    = (cur_row == ROW_W'(FULL_H - 1));
    end

    // Advance the position by one for each live pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TRK_IDLE;
            col_q <= '0;
            row_q <= '0;
        end else if (cur_live) begin
            st_q <= TRK_RUN;
            if (col_last) begin
                col_q <= '0;
                row_q <= row_last ? '0 : cur_row + ROW_W'(1);
            end else begin
                col_q <= cur_col + COL_W'(1);
                row_q <= cur_row;
            end
        end
    end

    // R6: the stored position never leaves the frame.
    p_col_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRK_RUN) |-> (col_q < COL_W'(FULL_W)));
    p_row_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRK_RUN) |-> (row_q < ROW_W'(FULL_H)));
    // R7: once tracking starts it only ends with reset.
    p_run_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRK_RUN) |=> (st_q == TRK_RUN));

endmodule

// File: rtl/store_decimator.sv
// Module: store_decimator
// Keeps the pixels whose column and row are both even and turns each into a
// registered write at base + (row/2)*RED_W + col/2. The slot is captured at
// start of frame. A captured slot out of range suppresses all writes of that
// frame and raises store_err until the next start of frame with a good slot.
// Assumes position inputs come from raster_tracker for the same cycle.
module store_decimator #(
    parameter int SLOTS   = 6,
    parameter int SLOT_W  = 3,
    parameter int ADDR_W  = 19,
    parameter int PIX_W   = 8,
    parameter int COL_W   = 10,
    parameter int ROW_W   = 9,
    parameter int RED_W   = 320,
    parameter int SLOT_SZ = 76800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_live,
    input  logic              frame_start,
    input  logic [COL_W-1:0]  cur_col,
    input  logic [ROW_W-1:0]  cur_row,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic [PIX_W-1:0]  in_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PIX_W-1:0]  wr_data,
    output logic              store_err
);

    localparam int SPAN = SLOTS * SLOT_SZ;

    logic [SLOT_W-1:0] slot_q;
    logic              err_q;
    logic [SLOT_W-1:0] slot_cur;
    logic              err_cur;
    logic [ADDR_W-1:0] base_cur;
    logic              bad_cur;
    logic              keep;
    logic [ADDR_W-1:0] addr_cur;

    slot_base #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W),
        .ADDR_W (ADDR_W),
        .SLOT_SZ(SLOT_SZ)
    ) i_base (
        .slot    (slot_cur),
        .base    (base_cur),
        .slot_bad(bad_cur)
    );

    // Slot and error for this pixel: fresh at start of frame, held otherwise.
    always_comb begin
        slot_cur = frame_start ? in_slot : slot_q;
        err_cur  = frame_start ? bad_cur : err_q;
        keep     = cur_live && !err_cur && !cur_col[0] && !cur_row[0];
        addr_cur = base_cur
                 + ADDR_W'(cur_row >> 1) * ADDR_W'(RED_W)
                 + ADDR_W'(cur_col >> 1);
    end

    // Capture the frame's slot and its error state at start of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            err_q  <= 1'b0;
        end else if (frame_start) begin
            slot_q <= in_slot;
            err_q  <= bad_cur;
        end
    end

    // Register the write for each kept pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= keep;
            if (keep) begin
                wr_addr <= addr_cur;
                wr_data <= in_data;
            end
        end
    end

    assign store_err = err_q;

    // R4: every write lands inside the region covered by the slots.
    p_addr_in_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr < ADDR_W'(SPAN)));
    // R5: no write is issued while the frame's slot is in error.
    p_no_write_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !store_err);

endmodule

// File: rtl/view_mapper.sv
// Module: view_mapper
// Turns a screen coordinate into the read address of the stored pixel that
// covers it: base + (y>>1)*RED_W + (x>>1), registered one clock. A display
// slot out of range raises view_err and gives address zero.
// Assumes coordinates come from a display timing generator in the active area.
module view_mapper #(
    parameter int SLOTS   = 6,
    parameter int SLOT_W  = 3,
    parameter int ADDR_W  = 19,
    parameter int COL_W   = 10,
    parameter int ROW_W   = 9,
    parameter int RED_W   = 320,
    parameter int SLOT_SZ = 76800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  view_x,
    input  logic [ROW_W-1:0]  view_y,
    input  logic [SLOT_W-1:0] view_slot,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              view_err
);

    logic [ADDR_W-1:0] base_v;
    logic              bad_v;
    logic [ADDR_W-1:0] addr_v;

    slot_base #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W),
        .ADDR_W (ADDR_W),
        .SLOT_SZ(SLOT_SZ)
    ) i_base (
        .slot    (view_slot),
        .base    (base_v),
        .slot_bad(bad_v)
    );

    // Halve both coordinates so that each stored pixel covers 2 x 2 on screen.
    always_comb begin
        addr_v = base_v
               + ADDR_W'(view_y >> 1) * ADDR_W'(RED_W)
               + ADDR_W'(view_x >> 1);
    end

    // Register the read address and the slot error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr  <= '0;
            view_err <= 1'b0;
        end else begin
            rd_addr  <= bad_v ? '0 : addr_v;
            view_err <= bad_v;
        end
    end

    // R9: a display slot error always comes with address zero.
    p_err_zero_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        view_err |-> (rd_addr == '0));

endmodule

// File: rtl/frame_halver.sv
// Module: frame_halver (top)
// Two-to-one image scaler. The store path decimates a raster pixel stream by
// two in each dimension into a slot of a linear frame memory. The display
// path maps screen coordinates to read addresses that repeat each stored
// pixel over a 2 x 2 block. Assumes one byte per pixel and synchronous reset.
module frame_halver
    import frame_halver_pkg::*;
#(
    parameter int FULL_W = DEF_FULL_W,
    parameter int FULL_H = DEF_FULL_H,
    parameter int PIX_W  = DEF_PIX_W,
    parameter int SLOTS  = DEF_SLOTS,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int SLOT_W = $clog2(SLOTS + 1),
    parameter int COL_W  = $clog2(FULL_W),
    parameter int ROW_W  = $clog2(FULL_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              pix_sof,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic [SLOT_W-1:0] store_slot,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PIX_W-1:0]  wr_data,
    output logic              store_err,
    input  logic [COL_W-1:0]  view_x,
    input  logic [ROW_W-1:0]  view_y,
    input  logic [SLOT_W-1:0] view_slot,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              view_err
);

    localparam int RED_W   = FULL_W / 2;
    localparam int RED_H   = FULL_H / 2;
    localparam int SLOT_SZ = RED_W * RED_H;

    logic             cur_live;
    logic             frame_start;
    logic [COL_W-1:0] cur_col;
    logic [ROW_W-1:0] cur_row;

    raster_tracker #(
        .FULL_W(FULL_W),
        .FULL_H(FULL_H),
        .COL_W (COL_W),
        .ROW_W (ROW_W)
    ) i_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (pix_valid),
        .in_sof     (pix_sof),
        .cur_live   (cur_live),
        .frame_start(frame_start),
        .cur_col    (cur_col),
        .cur_row    (cur_row)
    );

    store_decimator #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W),
        .ADDR_W (ADDR_W),
        .PIX_W  (PIX_W),
        .COL_W  (COL_W),
        .ROW_W  (ROW_W),
        .RED_W  (RED_W),
        .SLOT_SZ(SLOT_SZ)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_live   (cur_live),
        .frame_start(frame_start),
        .cur_col    (cur_col),
        .cur_row    (cur_row),
        .in_slot    (store_slot),
        .in_data    (pix_data),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .store_err  (store_err)
    );

    view_mapper #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W),
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .ROW_W  (ROW_W),
        .RED_W  (RED_W),
        .SLOT_SZ(SLOT_SZ)
    ) i_view (
        .clk      (clk),
        .rst_n    (rst_n),
        .view_x   (view_x),
        .view_y   (view_y),
        .view_slot(view_slot),
        .rd_addr  (rd_addr),
        .view_err (view_err)
    );

endmodule

// File: tb/test_frame_halver.sv
`timescale 1ns/1ps
// Bench for frame_halver: a behavioural reference model is updated on every
// rising edge and compared with the outputs on every falling edge.
module test_frame_halver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic        pix_sof = 1'b0;
    logic [7:0]  pix_data = '0;
    logic [2:0]  store_slot = '0;
    logic        wr_valid;
    logic [18:0] wr_addr;
    logic [7:0]  wr_data;
    logic        store_err;
    logic [9:0]  view_x = '0;
    logic [8:0]  view_y = '0;
    logic [2:0]  view_slot = '0;
    logic [18:0] rd_addr;
    logic        view_err;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    frame_halver i_frame_halver (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_data(pix_data),
        .store_slot(store_slot),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .store_err(store_err),
        .view_x(view_x), .view_y(view_y), .view_slot(view_slot),
        .rd_addr(rd_addr), .view_err(view_err)
    );

    // Reference model state
    int  m_col = 0, m_row = 0, m_slot = 0;
    bit  m_armed = 0, m_err = 0, m_live = 0;
    bit  e_wv = 0, e_serr = 0, e_verr = 0;
    int  e_wa = 0, e_wd = 0, e_ra = 0;

    always @(posedge clk) begin
        int c, r;
        m_live <= rst_n;
        if (!rst_n) begin
            m_col = 0; m_row = 0; m_slot = 0; m_armed = 0; m_err = 0;
            e_wv = 0; e_serr = 0; e_verr = 0; e_ra = 0;
        end else begin
            e_wv = 0;
            if (pix_valid && (pix_sof || m_armed)) begin
                if (pix_sof) begin
                    m_armed = 1; m_slot = store_slot; m_err = (store_slot >= 6);
                    c = 0; r = 0;
                end else begin
                    c = m_col; r = m_row;
                end
                if (!m_err && (c % 2 == 0) && (r % 2 == 0)) begin
                    e_wv = 1;
                    e_wa = m_slot * 76800 + (r / 2) * 320 + c / 2;
                    e_wd = pix_data;
                end
                m_col = c + 1;
                m_row = r;
                if (m_col == 640) begin
                    m_col = 0;
                    m_row = (r + 1 == 480) ? 0 : r + 1;
                end
            end
            e_serr = m_err;
            e_verr = (view_slot >= 6);
            e_ra   = e_verr ? 0 : view_slot * 76800 + (view_y / 2) * 320 + view_x / 2;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (m_live && rst_n) begin
            check(wr_valid == e_wv, (e_wv ? "R3" : "R2"), {phase, " wr_valid"}, wr_valid, e_wv);
            if (e_wv && wr_valid) begin
                check(wr_addr == 19'(e_wa), "R3", {phase, " wr_addr"}, wr_addr, e_wa);
                check(wr_data == 8'(e_wd), "R3", {phase, " wr_data"}, wr_data, e_wd);
            end
            check(store_err == e_serr, "R5", {phase, " store_err"}, store_err, e_serr);
            check(rd_addr == 19'(e_ra), (e_verr ? "R9" : "R8"), {phase, " rd_addr"}, rd_addr, e_ra);
            check(view_err == e_verr, "R9", {phase, " view_err"}, view_err, e_verr);
        end
    end

    // Drive one cycle of stimulus; the display side gets random coordinates.
    task automatic px(input bit v, input bit sof, input int vs_max);
        @(negedge clk);
        pix_valid = v;
        pix_sof   = sof;
        pix_data  = 8'($urandom);
        view_x    = 10'($urandom_range(639, 0));
        view_y    = 9'($urandom_range(479, 0));
        view_slot = 3'($urandom_range(vs_max, 0));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(wr_valid == 0, "R1", "wr_valid in reset", wr_valid, 0);
        check(store_err == 0, "R1", "store_err in reset", store_err, 0);
        check(view_err == 0, "R1", "view_err in reset", view_err, 0);
        check(rd_addr == 0, "R1", "rd_addr in reset", rd_addr, 0);
        rst_n = 1'b1;

        // R7: pixels before the first start of frame are dropped
        phase = "R7 pre-sof";
        for (int i = 0; i < 12; i++) px(1, 0, 5);

        // R6/R3: frame in slot 2, two rows and a bit, crossing the row wrap
        phase = "R6 slot2 frame";
        store_slot = 3'd2;
        px(1, 1, 5);
        for (int i = 1; i < 1400; i++) px(1, 0, 5);

        // R7: idle gaps do not advance the position
        phase = "R7 idle gaps";
        for (int i = 0; i < 200; i++) px(i % 3 != 0, 0, 5);

        // R4: slot changes in mid-frame are ignored
        phase = "R4 slot change mid-frame";
        for (int i = 0; i < 300; i++) begin
            store_slot = 3'(i % 8);
            px(1, 0, 5);
        end

        // R5: out-of-range slot 7 suppresses the frame
        phase = "R5 bad slot";
        store_slot = 3'd7;
        px(1, 1, 7);
        for (int i = 0; i < 700; i++) px(1, 0, 7);

        // R5/R4: last good slot 5 clears the error
        phase = "R4 last slot";
        store_slot = 3'd5;
        px(1, 1, 7);
        for (int i = 0; i < 700; i++) px(1, 0, 7);

        // R6: restart at start of frame in mid-row, slot 0
        phase = "R6 mid-row restart";
        store_slot = 3'd0;
        for (int i = 0; i < 3; i++) begin
            px(1, 1, 7);
            for (int k = 0; k < 37 + i; k++) px(1, 0, 7);
        end

        // R8: 2 x 2 repetition, explicit neighbours
        phase = "R8 block";
        px(0, 0, 0);
        for (int dx = 0; dx < 2; dx++) begin
            for (int dy = 0; dy < 2; dy++) begin
                @(negedge clk);
                view_slot = 3'd3;
                view_x = 10'(638 + dx);
                view_y = 9'(478 + dy);
                @(negedge clk);
                check(rd_addr == 19'(3 * 76800 + 239 * 320 + 319), "R8",
                      "2x2 corner block", rd_addr, 3 * 76800 + 239 * 320 + 319);
            end
        end
        px(0, 0, 0);
        px(0, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule